// File: doc/BRIEF.md
# Two-Bank Register File with Indirect Pointer

This block is the 8-bit data memory of a small accumulator-style processor core. Every access carries a 7-bit offset taken from the instruction. A bank bit, kept in bit 5 of the status register, extends that offset into one of two 128-location banks. Each location resolves to one of five kinds of target. The first is a core register that both banks share. The second is a peripheral-control register that exists separately in each bank. The third is general-purpose SRAM that both banks see at the same offsets. The fourth is an unimplemented hole that reads as zero. The fifth is the pointer pseudo-register at offset 00h.

An access to offset 00h does not reach a physical register. It is redirected to the offset held in the pointer register (the low seven bits), in the bank that the status bit currently selects. Reads are combinational from the address, so a core can fetch an operand and use it in the same cycle. A write lands on the rising clock edge while the write enable is high.

The peripherals themselves lie outside this block. Their control registers exist here only as plain 8-bit storage.

Top module: `banked_file_mem`

## Requirements
- R1: Bit 5 of the status register (offset 03h) selects the bank for every access: 0 selects bank 0 and 1 selects bank 1. The output `bank_o` shows this bit.
- R2: Offsets 0Ch–4Fh are 68 bytes of general-purpose RAM. The same offset reaches the same byte in both banks.
- R3: Offsets 02h (program-counter low), 03h (status), 04h (pointer), 0Ah (program-counter latch) and 0Bh (interrupt control) each map to a single register that both banks share.
- R4: Offsets 01h, 05h, 06h, 08h and 09h hold a separate register in each bank. A write in one bank leaves the other bank's register unchanged.
- R5: Offset 07h and offsets 50h–7Fh read as zero in both banks. Writes to them have no effect.
- R6: An access to offset 00h reads or writes the location whose offset is the pointer register's bits 6:0, in the bank given by the status bit. Bit 7 of the pointer has no effect on that choice.
- R7: An access through offset 00h whose pointer offset is itself 00h reads zero, and writing to it changes nothing.
- R8: Reset is synchronous and active high. It clears the status register and the pointer register to 00h. It sets the two bank-1 direction registers (bank 1, offsets 05h and 06h) to FFh. Every other shared and banked register returns to 00h.
- R9: Read data follows the address within the same cycle. A write takes effect only at a rising clock edge with `wr_en_i` high. With `wr_en_i` low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 7 | Offset within the selected bank; 00h means go through the pointer |
| wr_en_i | input | 1 | Write enable for the current access |
| wr_data_i | input | 8 | Data to write |
| rd_data_o | output | 8 | Combinational read data for the current access |
| bank_o | output | 1 | Current bank bit (status bit 5) |
| fsr_o | output | 8 | Current pointer register value |

## Verification
Redirection through the pointer and a change of bank can fall in the same cycle. This happens when an indirect write targets the status register itself. The bench points the pointer at 03h and writes a value with bit 5 set through offset 00h. The decode of that cycle must still use the old bank. From the next cycle on, `bank_o`, a direct read of the status register, and a second indirect write into a bank-1 direction register must all show that the new bank has taken hold. A bench-side model, built from the requirements, checks that the bank-0 register at the same offset stays unchanged.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
    localparam int DW       = 8;
    localparam int OFFW     = 7;
    localparam int NBANK    = 2;
    localparam int NCORE    = 5;
    localparam int NPERB    = 5;
    localparam int GPR_LO   = 12;
    localparam int GPR_HI   = 79;
    localparam int GPR_N    = GPR_HI - GPR_LO + 1;
    localparam int GIDXW    = $clog2(GPR_N);
    localparam int SLOTW    = 3;
    localparam int STAT_SLOT = 1;
    localparam int PTR_SLOT  = 2;
    localparam int BANK_BIT  = 5;

    typedef enum logic [2:0] {
        RG_HOLE,
        RG_NULL,
        RG_CORE,
        RG_PERB,
        RG_GPR
    } region_e;

    typedef struct packed {
        region_e            region;
        logic [SLOTW-1:0]   slot;
        logic [GIDXW-1:0]   gidx;
        logic               bank;
    } target_t;

    function automatic target_t resolve(input logic bank, input logic [OFFW-1:0] off);
        target_t t;
        t.region = RG_HOLE;
        t.slot   = '0;
        t.gidx   = '0;
        t.bank   = bank;
        unique case (off)
            7'h00: t.region = RG_NULL;
            7'h02: begin t.region = RG_CORE; t.slot = 3'd0; end
            7'h03: begin t.region = RG_CORE; t.slot = 3'd1; end
            7'h04: begin t.region = RG_CORE; t.slot = 3'd2; end
            7'h0A: begin t.region = RG_CORE; t.slot = 3'd3; end
            7'h0B: begin t.region = RG_CORE; t.slot = 3'd4; end
            7'h01: begin t.region = RG_PERB; t.slot = 3'd0; end
            7'h05: begin t.region = RG_PERB; t.slot = 3'd1; end
            7'h06: begin t.region = RG_PERB; t.slot = 3'd2; end
            7'h08: begin t.region = RG_PERB; t.slot = 3'd3; end
            7'h09: begin t.region = RG_PERB; t.slot = 3'd4; end
            default: begin
                if (int'(off) >= GPR_LO && int'(off) <= GPR_HI) begin
                    t.region = RG_GPR;
                    t.gidx   = GIDXW'(int'(off) - GPR_LO);
                end
            end
        endcase
        return t;
    endfunction

    function automatic logic [DW-1:0] perb_reset(input int b, input int s);
        return (b == 1 && (s == 1 || s == 2)) ? {DW{1'b1}} : '0;
    endfunction
endpackage

// File: rtl/bdm_decoder.sv
module bdm_decoder
    import bdm_pkg::*;
(
    input  logic [OFFW-1:0] addr_i,
    input  logic            bank_i,
    input  logic [OFFW-1:0] ptr_off_i,
    output target_t         tgt_o
);
    logic [OFFW-1:0] eff_off;
    logic            via_ptr;

    always_comb begin
        via_ptr = (addr_i == '0);
        eff_off = via_ptr ? ptr_off_i : addr_i;
        tgt_o   = resolve(bank_i, eff_off);
    end
endmodule

// File: rtl/bdm_core_regs.sv
module bdm_core_regs
    import bdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [SLOTW-1:0] slot_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic             bank_o,
    output logic [DW-1:0]    ptr_o
);
    logic [DW-1:0] core_q [NCORE];

    genvar g;
    generate
        for (g = 0; g < NCORE; g++) begin : g_core
            always_ff @(posedge clk) begin
                if (rst)
                    core_q[g] <= '0;
                else if (we_i && int'(slot_i) == g)
                    core_q[g] <= wdata_i;
            end
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NCORE; i++)
            if (int'(slot_i) == i) rdata_o = core_q[i];
    end

    assign bank_o = core_q[STAT_SLOT][BANK_BIT];
    assign ptr_o  = core_q[PTR_SLOT];

    a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (core_q[STAT_SLOT] == '0 && ptr_o == '0));

    a_r9_status_hold: assert property (@(posedge clk) disable iff (rst)
        !(we_i && int'(slot_i) == STAT_SLOT) |=> $stable(core_q[STAT_SLOT]));
endmodule

// File: rtl/bdm_banked_regs.sv
module bdm_banked_regs
    import bdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic             bank_i,
    input  logic [SLOTW-1:0] slot_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o
);
    logic [DW-1:0] per_q [NBANK][NPERB];

    genvar b, s;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            for (s = 0; s < NPERB; s++) begin : g_slot
                always_ff @(posedge clk) begin
                    if (rst)
                        per_q[b][s] <= perb_reset(b, s);
                    else if (we_i && int'(bank_i) == b && int'(slot_i) == s)
                        per_q[b][s] <= wdata_i;
                end
            end
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NPERB; i++)
            if (int'(slot_i) == i) rdata_o = per_q[bank_i][i];
    end

    a_r8_dir_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (per_q[1][1] == {DW{1'b1}} && per_q[1][2] == {DW{1'b1}}));

    a_r4_other_bank_hold: assert property (@(posedge clk) disable iff (rst)
        (we_i && bank_i) |=> $stable(per_q[0][0]) && $stable(per_q[0][1]));
endmodule

// File: rtl/bdm_gpr_ram.sv
module bdm_gpr_ram
    import bdm_pkg::*;
#(
    parameter int DEPTH = GPR_N,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] idx_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i && int'(idx_i) < DEPTH)
            mem_q[idx_i] <= wdata_i;
    end

    assign rdata_o = (int'(idx_i) < DEPTH) ? mem_q[idx_i] : '0;

    a_r2_idx_range: assert property (@(posedge clk)
        we_i |-> int'(idx_i) < DEPTH);
endmodule

// File: rtl/banked_file_mem.sv
module banked_file_mem
    import bdm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OFFW-1:0] addr_i,
    input  logic            wr_en_i,
    input  logic [DW-1:0]   wr_data_i,
    output logic [DW-1:0]   rd_data_o,
    output logic            bank_o,
    output logic [DW-1:0]   fsr_o
);
    target_t       tgt;
    logic          bank;
    logic [DW-1:0] ptr;
    logic [DW-1:0] core_rd, perb_rd, gpr_rd;
    logic          core_we, perb_we, gpr_we;

    bdm_decoder u_dec (
        .addr_i    (addr_i),
        .bank_i    (bank),
        .ptr_off_i (ptr[OFFW-1:0]),
        .tgt_o     (tgt)
    );

    assign core_we = wr_en_i && (tgt.region == RG_CORE);
    assign perb_we = wr_en_i && (tgt.region == RG_PERB);
    assign gpr_we  = wr_en_i && (tgt.region == RG_GPR);

    bdm_core_regs u_core (
        .clk     (clk),
        .rst     (rst),
        .we_i    (core_we),
        .slot_i  (tgt.slot),
        .wdata_i (wr_data_i),
        .rdata_o (core_rd),
        .bank_o  (bank),
        .ptr_o   (ptr)
    );

    bdm_banked_regs u_perb (
        .clk     (clk),
        .rst     (rst),
        .we_i    (perb_we),
        .bank_i  (tgt.bank),
        .slot_i  (tgt.slot),
        .wdata_i (wr_data_i),
        .rdata_o (perb_rd)
    );

    bdm_gpr_ram #(.DEPTH(GPR_N)) u_gpr (
        .clk     (clk),
        .we_i    (gpr_we),
        .idx_i   (tgt.gidx),
        .wdata_i (wr_data_i),
        .rdata_o (gpr_rd)
    );

    always_comb begin
        unique case (tgt.region)
            RG_CORE: rd_data_o = core_rd;
            RG_PERB: rd_data_o = perb_rd;
            RG_GPR:  rd_data_o = gpr_rd;
            default: rd_data_o = '0;
        endcase
    end

    assign bank_o = bank;
    assign fsr_o  = ptr;

    a_r5_hole_zero: assert property (@(posedge clk) disable iff (rst)
        (tgt.region == RG_HOLE) |-> rd_data_o == '0);

    a_r7_null_zero: assert property (@(posedge clk) disable iff (rst)
        (tgt.region == RG_NULL) |-> rd_data_o == '0);
endmodule

// File: tb/banked_file_mem_bench.sv
module banked_file_mem_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] rd;
    logic       bank;
    logic [7:0] fsr;

    int tests = 0;
    int fails = 0;

    logic [7:0] m_gpr [68];
    logic [7:0] m_core [5];
    logic [7:0] m_per [2][5];

    always #5 clk = ~clk;

    banked_file_mem u_banked_file_mem (
        .clk(clk), .rst(rst), .addr_i(addr), .wr_en_i(we),
        .wr_data_i(wd), .rd_data_o(rd), .bank_o(bank), .fsr_o(fsr)
    );

    function automatic int core_idx(input logic [6:0] o);
        case (o)
            7'h02: return 0; 7'h03: return 1; 7'h04: return 2;
            7'h0A: return 3; 7'h0B: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic int per_idx(input logic [6:0] o);
        case (o)
            7'h01: return 0; 7'h05: return 1; 7'h06: return 2;
            7'h08: return 3; 7'h09: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [6:0] eff(input logic [6:0] a);
        return (a == 0) ? m_core[2][6:0] : a;
    endfunction

    function automatic logic [7:0] mread(input logic [6:0] a);
        logic [6:0] o = eff(a);
        int b = int'(m_core[1][5]);
        if (o == 0) return 8'h00;
        if (core_idx(o) >= 0) return m_core[core_idx(o)];
        if (per_idx(o) >= 0) return m_per[b][per_idx(o)];
        if (o >= 7'h0C && o <= 7'h4F) return m_gpr[int'(o) - 12];
        return 8'h00;
    endfunction

    function automatic string tag_of(input logic [6:0] o);
        if (o == 0) return "R7";
        if (core_idx(o) >= 0) return "R3";
        if (per_idx(o) >= 0) return "R4";
        if (o >= 7'h0C && o <= 7'h4F) return "R2";
        return "R5";
    endfunction

    task automatic mwrite(input logic [6:0] a, input logic [7:0] d);
        logic [6:0] o = eff(a);
        int b = int'(m_core[1][5]);
        if (o == 0) return;
        if (core_idx(o) >= 0) m_core[core_idx(o)] = d;
        else if (per_idx(o) >= 0) m_per[b][per_idx(o)] = d;
        else if (o >= 7'h0C && o <= 7'h4F) m_gpr[int'(o) - 12] = d;
    endtask

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag, input string what);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wd = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        mwrite(a, d);
    endtask

    task automatic rd_chk(input logic [6:0] a, input string tag);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1;
        chk(rd, mread(a), tag, $sformatf("read offset %h bank %0d", a, m_core[1][5]));
    endtask

    task automatic set_bank(input int b);
        wr(7'h03, (b != 0) ? 8'h20 : 8'h00);
        #1;
        chk({7'b0, bank}, b[7:0], "R1", "bank_o after status write");
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) begin
            m_core[i] = 8'h00;
            m_per[0][i] = 8'h00;
            m_per[1][i] = (i == 1 || i == 2) ? 8'hFF : 8'h00;
        end
        for (int i = 0; i < 68; i++) m_gpr[i] = 8'h00;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8: reset state
        #1;
        chk({7'b0, bank}, 8'h00, "R8", "bank bit after reset");
        chk(fsr, 8'h00, "R8", "pointer after reset");
        @(negedge clk); addr = 7'h03; #1; chk(rd, 8'h00, "R8", "status after reset");
        @(negedge clk); addr = 7'h01; #1; chk(rd, 8'h00, "R8", "bank0 01h after reset");
        set_bank(1);
        @(negedge clk); addr = 7'h05; #1; chk(rd, 8'hFF, "R8", "dir reg 05h after reset");
        @(negedge clk); addr = 7'h06; #1; chk(rd, 8'hFF, "R8", "dir reg 06h after reset");
        set_bank(0);

        // R2 R3 R4 R5: write sweep over both banks, then read back both banks
        for (int b = 0; b < 2; b++) begin
            set_bank(b);
            for (int o = 1; o < 128; o++) begin
                if (o == 3) continue;
                wr(7'(o), 8'((o * 7 + b * 83 + 1) & 255));
            end
        end
        for (int b = 0; b < 2; b++) begin
            set_bank(b);
            for (int o = 1; o < 128; o++) rd_chk(7'(o), tag_of(7'(o)));
        end

        // R6: indirect reads and writes agree with direct access; pointer bit 7 ignored
        for (int b = 0; b < 2; b++) begin
            set_bank(b);
            for (int o = 1; o < 128; o++) begin
                if (o == 3 || o == 4) continue;
                wr(7'h04, {(b == 0) ? 1'b1 : 1'b0, 7'(o)});
                rd_chk(7'h00, "R6");
                wr(7'h00, 8'((o * 13 + b * 29 + 5) & 255));
                rd_chk(7'(o), "R6");
            end
        end
        set_bank(0);
        for (int o = 1; o < 128; o++) rd_chk(7'(o), "R6");

        // R7: pointer at offset 0 (bit 7 clear and set)
        wr(7'h04, 8'h00);
        rd_chk(7'h00, "R7");
        wr(7'h00, 8'hA5);
        rd_chk(7'h03, "R7");
        rd_chk(7'h04, "R7");
        wr(7'h04, 8'h80);
        rd_chk(7'h00, "R7");
        wr(7'h00, 8'h5A);
        rd_chk(7'h04, "R7");
        for (int o = 1; o < 128; o++) rd_chk(7'(o), "R7");

        // R9: write enable low leaves state untouched
        @(negedge clk);
        addr = 7'h20; wd = ~mread(7'h20); we = 1'b0;
        @(negedge clk);
        #1; chk(rd, mread(7'h20), "R9", "gpr with enable low");
        addr = 7'h03; wd = 8'h20; we = 1'b0;
        @(negedge clk);
        #1; chk({7'b0, bank}, 8'h00, "R9", "status with enable low");

        // R1 + R6 collision: indirect write flips the bank
        wr(7'h04, 8'h03);
        wr(7'h00, 8'h20);
        #1;
        chk({7'b0, bank}, 8'h01, "R1", "bank after indirect status write");
        rd_chk(7'h03, "R1");
        wr(7'h04, 8'h05);
        wr(7'h00, 8'h3C);
        rd_chk(7'h05, "R4");
        chk(mread(7'h05), 8'h3C, "R6", "model bank1 dir reg");
        set_bank(0);
        rd_chk(7'h05, "R4");
        rd_chk(7'h00, "R6");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule